// File: doc/BRIEF.md
# Accumulator-based 8-bit processor core

This block is a small stored-program processor built around a single 8-bit accumulator. It also has a program counter, an instruction register, one operand holding register, eight general registers and two flags, carry and zero. It fetches its instructions from an external byte-wide program store. It presents the program counter on the address bus and pulls an active-low read enable while it expects the store to return the byte at that address. It writes nothing back to that store.

Every instruction takes exactly three clocks: a fetch, a decode and an execute. Immediate and jump opcodes carry a second byte, which is read during decode. Register-source opcodes pick their operand from the register file during decode. The result lands in the accumulator, a general register, the carry flag or the program counter during execute. A dedicated adder forms relative jump targets, so the data ALU never sees program-counter arithmetic. The accumulator and both flags are brought out as ports so that a system can observe the core's progress.

Top module: `acc8_core`

## Requirements
- R1: A clock edge with `rst_n` low clears the program counter, accumulator, carry, zero and all eight general registers, and leaves the core in fetch, so the first fetch after reset reads address 00h.
- R2: Each instruction occupies exactly three clocks in the order fetch, decode, execute. `mem_rd_n` is low in every fetch and high in every execute.
- R3: In fetch, `mem_addr` equals the program counter, the returned byte becomes the opcode, and the program counter increases by one.
- R4: For opcodes 74h, 34h, 80h and 60h, decode drives `mem_rd_n` low at the next address, keeps the returned byte as the operand, and advances the program counter by one. For all other opcodes `mem_rd_n` stays high in decode.
- R5: 74h loads the immediate byte into the accumulator. E8h+n copies register n into the accumulator. F8h+n copies the accumulator into register n, with n taken from opcode bits [2:0].
- R6: 34h (immediate) and 38h+n (register n) form accumulator + operand + carry. The low 8 bits go to the accumulator and the ninth bit goes to carry.
- R7: 48h+n, 58h+n and 68h+n replace the accumulator with its bitwise OR, AND and XOR with register n, and leave carry unchanged.
- R8: C4h exchanges the two nibbles of the accumulator. C3h clears carry and D3h sets carry, and neither touches the accumulator.
- R9: Zero is rewritten on every accumulator write to show whether the new value is 00h. Instructions that do not write the accumulator leave zero unchanged.
- R10: 80h sets the program counter to the opcode address + 2 + the second byte, read as a signed two's-complement offset (FEh jumps back onto itself).
- R11: 60h jumps exactly as 80h does when the accumulator is 00h. Otherwise execution continues at the opcode address + 2.
- R12: Any other opcode is a one-byte, three-clock no-operation that changes no register or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Program-store address, always the program counter |
| mem_rd_n | output | 1 | Program-store read enable, active low |
| mem_data | input | 8 | Byte returned by the program store |
| acc_out | output | 8 | Current accumulator value |
| c_out | output | 1 | Current carry flag |
| z_out | output | 1 | Current zero flag |

## Verification
The carry-out of the adder and the recomputation of the zero flag fall in the same execute cycle. The sharpest case is an add whose 8-bit sum wraps to 00h, where both flags must rise together. The directed program provokes this with 01h + FEh + carry-in 1. It is judged after that execute edge by requiring the accumulator to be 00h with both carry and zero set. A following CLR C must then drop carry and leave zero set. A taken zero-test jump comes next and reads the accumulator that the add left behind, and the check confirms that the padding bytes it skips never run.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
// Package acc8_pkg
// Shared phase and ALU encodings, the control word type and the opcode
// decoder for the accumulator core. Assumes 8-bit opcodes.
package acc8_pkg;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ALU_PASS = 3'd0,
        ALU_ADDC = 3'd1,
        ALU_OR   = 3'd2,
        ALU_AND  = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_SWAP = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic    two_byte;  // second byte is read during decode
        logic    src_reg;   // operand comes from the register file
        logic    acc_we;    // execute writes the accumulator
        logic    reg_we;    // execute writes a general register
        logic    c_we;      // execute writes carry
        logic    c_alu;     // carry source is the adder
        logic    c_val;     // constant carry value
        logic    is_jmp;    // relative jump
        logic    is_jz;     // jump only on zero accumulator
        alu_op_e op;
    } ctl_s;

    // Map an opcode to its control word; unknown opcodes give all zeros (no-op).
    function automatic ctl_s decode_op(input logic [7:0] opc);
        ctl_s d;
        d = '0;
        case (opc)
            8'h74: begin d.two_byte = 1'b1; d.acc_we = 1'b1; end
            8'h34: begin d.two_byte = 1'b1; d.acc_we = 1'b1; d.op = ALU_ADDC;
                         d.c_we = 1'b1; d.c_alu = 1'b1; end
            8'h80: begin d.two_byte = 1'b1; d.is_jmp = 1'b1; end
            8'h60: begin d.two_byte = 1'b1; d.is_jmp = 1'b1; d.is_jz = 1'b1; end
            8'hC4: begin d.acc_we = 1'b1; d.op = ALU_SWAP; end
            8'hC3: begin d.c_we = 1'b1; d.c_val = 1'b0; end
            8'hD3: begin d.c_we = 1'b1; d.c_val = 1'b1; end
            default: begin
                case (opc[7:3])
                    5'b11101: begin d.src_reg = 1'b1; d.acc_we = 1'b1; end
                    5'b11111: begin d.reg_we = 1'b1; end
                    5'b00111: begin d.src_reg = 1'b1; d.acc_we = 1'b1; d.op = ALU_ADDC;
                                    d.c_we = 1'b1; d.c_alu = 1'b1; end
                    5'b01001: begin d.src_reg = 1'b1; d.acc_we = 1'b1; d.op = ALU_OR;  end
                    5'b01011: begin d.src_reg = 1'b1; d.acc_we = 1'b1; d.op = ALU_AND; end
                    5'b01101: begin d.src_reg = 1'b1; d.acc_we = 1'b1; d.op = ALU_XOR; end
                    default:  d = '0;
                endcase
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/acc8_alu.sv
`timescale 1ns/1ps
// Module acc8_alu
// Combinational data ALU: pass, add with carry, OR, AND, XOR and nibble swap.
// Assumes W is even so that the swap splits the word into equal halves.
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         cout
);
    localparam int H = W / 2;

    logic [W:0] sum;

    // Full-width sum including the incoming carry.
    always_comb sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

    // Select the result for the requested operation.
    always_comb begin
        cout = 1'b0;
        case (op)
            ALU_PASS: y = b;
            ALU_ADDC: begin y = sum[W-1:0]; cout = sum[W]; end
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            ALU_XOR:  y = a ^ b;
            ALU_SWAP: y = {a[H-1:0], a[W-1:H]};
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/acc8_regbank.sv
`timescale 1ns/1ps
// Module acc8_regbank
// N general registers of W bits with one write port and one combinational
// read port. Synchronous active-low reset clears every register.
module acc8_regbank #(
    parameter int W = 8,
    parameter int N = 8,
    localparam int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [W-1:0]     wdata,
    input  logic [SEL_W-1:0] rsel,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        // Register i: clear on reset, load when selected for writing.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && (wsel == SEL_W'(i)))
                regs[i] <= wdata;
        end
    end

    // Read the selected register.
    always_comb rdata = regs[rsel];
endmodule

// File: rtl/acc8_ctrl.sv
`timescale 1ns/1ps
// Module acc8_ctrl
// Three-phase sequencer (fetch, decode, execute, one clock each) and the
// opcode decoder. Assumes the opcode in ir is stable during decode and execute.
module acc8_ctrl
    import acc8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ir,
    output phase_e     phase,
    output ctl_s       ctl
);
    // Step through the three phases; reset returns to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= ST_FETCH;
        else begin
            case (phase)
                ST_FETCH:  phase <= ST_DECODE;
                ST_DECODE: phase <= ST_EXEC;
                default:   phase <= ST_FETCH;
            endcase
        end
    end

    // Decode the held opcode into control lines.
    always_comb ctl = decode_op(ir);
endmodule

// File: rtl/acc8_core.sv
`timescale 1ns/1ps
// Module acc8_core
// Accumulator-based stored-program core. Reads instructions from an external
// combinational program store (data valid in the same cycle as mem_rd_n low).
// Assumes DATA_W is 8 (opcode encodings are byte-wide) and ADDR_W >= DATA_W.
module acc8_core
    import acc8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] acc_out,
    output logic              c_out,
    output logic              z_out
);
    localparam int SEL_W = $clog2(NREG);

    phase_e            phase;
    ctl_s              ctl;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] aux_q;
    logic [DATA_W-1:0] acc_q;
    logic              c_q;
    logic              z_q;
    logic [DATA_W-1:0] reg_rd;
    logic [DATA_W-1:0] alu_y;
    logic              alu_c;
    logic [ADDR_W-1:0] rel_ext;
    logic [ADDR_W-1:0] jmp_tgt;
    logic              jmp_taken;
    logic              rd_decode;

    acc8_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .ir    (ir_q[7:0]),
        .phase (phase),
        .ctl   (ctl)
    );

    acc8_regbank #(.W(DATA_W), .N(NREG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ((phase == ST_EXEC) && ctl.reg_we),
        .wsel  (ir_q[SEL_W-1:0]),
        .wdata (acc_q),
        .rsel  (ir_q[SEL_W-1:0]),
        .rdata (reg_rd)
    );

    acc8_alu #(.W(DATA_W)) u_alu (
        .a    (acc_q),
        .b    (aux_q),
        .cin  (c_q),
        .op   (ctl.op),
        .y    (alu_y),
        .cout (alu_c)
    );

    // Separate relative-jump adder: sign-extend the offset and add to PC.
    always_comb begin
        rel_ext   = ADDR_W'($signed(aux_q));
        jmp_tgt   = pc_q + rel_ext;
        jmp_taken = ctl.is_jmp && (!ctl.is_jz || (acc_q == '0));
        rd_decode = (phase == ST_DECODE) && ctl.two_byte;
    end

    // Bus outputs and visible state.
    assign mem_addr = pc_q;
    assign mem_rd_n = !((phase == ST_FETCH) || rd_decode);
    assign acc_out  = acc_q;
    assign c_out    = c_q;
    assign z_out    = z_q;

    // Program counter: step in fetch and on second-byte reads, load on jumps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if ((phase == ST_FETCH) || rd_decode)
            pc_q <= pc_q + 1'b1;
        else if ((phase == ST_EXEC) && jmp_taken)
            pc_q <= jmp_tgt;
    end

    // Instruction register and operand register loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            aux_q <= '0;
        end else if (phase == ST_FETCH) begin
            ir_q <= mem_data;
        end else if (phase == ST_DECODE) begin
            if (ctl.two_byte)
                aux_q <= mem_data;
            else if (ctl.src_reg)
                aux_q <= reg_rd;
        end
    end

    // Accumulator and flags update in execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
        end else if (phase == ST_EXEC) begin
            if (ctl.acc_we) begin
                acc_q <= alu_y;
                z_q   <= (alu_y == '0);
            end
            if (ctl.c_we)
                c_q <= ctl.c_alu ? alu_c : ctl.c_val;
        end
    end
endmodule

// File: rtl/acc8_core_chk.sv
`timescale 1ns/1ps
// Module acc8_core_chk
// Property checker for acc8_core, bound to every instance. Observes the phase,
// program counter, opcode, accumulator and zero flag; drives nothing.
module acc8_core_chk
    import acc8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input phase_e            phase,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ir,
    input logic [DATA_W-1:0] acc,
    input logic              z,
    input logic              mem_rd_n
);
    logic writes_acc;
    logic has_second;
    logic is_jump;

    // Independent classification of the opcode from the encoding rules.
    always_comb begin
        has_second = (ir == 8'h74) || (ir == 8'h34) || (ir == 8'h80) || (ir == 8'h60);
        is_jump    = (ir == 8'h80) || (ir == 8'h60);
        writes_acc = (ir == 8'h74) || (ir == 8'h34) || (ir == 8'hC4) ||
                     (ir[7:3] == 5'b11101) || (ir[7:3] == 5'b00111) ||
                     (ir[7:3] == 5'b01001) || (ir[7:3] == 5'b01011) ||
                     (ir[7:3] == 5'b01101);
    end

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_FETCH) |=> (phase == ST_DECODE)); // R2
    AST_DECODE_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_DECODE) |=> (phase == ST_EXEC)); // R2
    AST_EXEC_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_EXEC) |=> (phase == ST_FETCH)); // R2
    AST_EXEC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_EXEC) |-> mem_rd_n); // R2
    AST_FETCH_STEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_FETCH) |=> (pc == $past(pc) + 1'b1)); // R3
    AST_SECOND_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_DECODE) && has_second) |=> (pc == $past(pc) + 1'b1)); // R4
    AST_ONE_BYTE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_DECODE) && !has_second) |=> $stable(pc)); // R4
    AST_NON_JUMP_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_EXEC) && !is_jump) |=> $stable(pc)); // R12
    AST_ZERO_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_EXEC) && writes_acc) |=> (z == (acc == '0))); // R9
    AST_ACC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_EXEC) |=> $stable(acc)); // R2
endmodule

bind acc8_core acc8_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .pc       (pc_q),
    .ir       (ir_q),
    .acc      (acc_q),
    .z        (z_q),
    .mem_rd_n (mem_rd_n)
);

// File: tb/acc8_core_bench.sv
`timescale 1ns/1ps
// Bench for acc8_core: a vector table holds a program and the expected
// accumulator/flags after each instruction; directed tests then cover reset
// and the backward jump.
module acc8_core_bench;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] arg;
        logic       two;
        logic [7:0] pad_n;
        logic [7:0] pad_b;
        logic [7:0] acc;
        logic       c;
        logic       z;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{8'h74, 8'h03, 1'b1, 8'd0, 8'h00, 8'h03, 1'b0, 1'b0, 8'd5},   // R5 MOV A,#03
        '{8'hF8, 8'h00, 1'b0, 8'd0, 8'h00, 8'h03, 1'b0, 1'b0, 8'd5},   // R5 MOV R0,A
        '{8'h74, 8'h0F, 1'b1, 8'd0, 8'h00, 8'h0F, 1'b0, 1'b0, 8'd5},   // R5
        '{8'hF9, 8'h00, 1'b0, 8'd0, 8'h00, 8'h0F, 1'b0, 1'b0, 8'd5},   // R5 MOV R1,A
        '{8'h74, 8'hF0, 1'b1, 8'd0, 8'h00, 8'hF0, 1'b0, 1'b0, 8'd5},   // R5
        '{8'hFA, 8'h00, 1'b0, 8'd0, 8'h00, 8'hF0, 1'b0, 1'b0, 8'd5},   // R5 MOV R2,A
        '{8'hE8, 8'h00, 1'b0, 8'd0, 8'h00, 8'h03, 1'b0, 1'b0, 8'd5},   // R5 MOV A,R0
        '{8'h39, 8'h00, 1'b0, 8'd0, 8'h00, 8'h12, 1'b0, 1'b0, 8'd6},   // R6 ADDC A,R1
        '{8'hD3, 8'h00, 1'b0, 8'd0, 8'h00, 8'h12, 1'b1, 1'b0, 8'd8},   // R8 SETB C
        '{8'h34, 8'hEE, 1'b1, 8'd0, 8'h00, 8'h01, 1'b1, 1'b0, 8'd6},   // R6 carry in and out
        '{8'h34, 8'hFE, 1'b1, 8'd0, 8'h00, 8'h00, 1'b1, 1'b1, 8'd6},   // R6 + R9 same cycle
        '{8'hC3, 8'h00, 1'b0, 8'd0, 8'h00, 8'h00, 1'b0, 1'b1, 8'd8},   // R8 CLR C, Z kept
        '{8'h60, 8'h02, 1'b1, 8'd2, 8'hD3, 8'h00, 1'b0, 1'b1, 8'd11},  // R11 taken
        '{8'hE9, 8'h00, 1'b0, 8'd0, 8'h00, 8'h0F, 1'b0, 1'b0, 8'd9},   // R9 Z cleared
        '{8'hD3, 8'h00, 1'b0, 8'd0, 8'h00, 8'h0F, 1'b1, 1'b0, 8'd8},   // R8
        '{8'h4A, 8'h00, 1'b0, 8'd0, 8'h00, 8'hFF, 1'b1, 1'b0, 8'd7},   // R7 ORL R2
        '{8'h58, 8'h00, 1'b0, 8'd0, 8'h00, 8'h03, 1'b1, 1'b0, 8'd7},   // R7 ANL R0
        '{8'h69, 8'h00, 1'b0, 8'd0, 8'h00, 8'h0C, 1'b1, 1'b0, 8'd7},   // R7 XRL R1
        '{8'hC4, 8'h00, 1'b0, 8'd0, 8'h00, 8'hC0, 1'b1, 1'b0, 8'd8},   // R8 SWAP
        '{8'h6A, 8'h00, 1'b0, 8'd0, 8'h00, 8'h30, 1'b1, 1'b0, 8'd7},   // R7 XRL R2
        '{8'h60, 8'h05, 1'b1, 8'd0, 8'h00, 8'h30, 1'b1, 1'b0, 8'd11},  // R11 not taken
        '{8'hA5, 8'h00, 1'b0, 8'd0, 8'h00, 8'h30, 1'b1, 1'b0, 8'd12},  // R12 undefined
        '{8'h00, 8'h00, 1'b0, 8'd0, 8'h00, 8'h30, 1'b1, 1'b0, 8'd12},  // R12 undefined
        '{8'h80, 8'h03, 1'b1, 8'd3, 8'hC4, 8'h30, 1'b1, 1'b0, 8'd10},  // R10 forward
        '{8'h68, 8'h00, 1'b0, 8'd0, 8'h00, 8'h33, 1'b1, 1'b0, 8'd7},   // R7 XRL R0
        '{8'h74, 8'h00, 1'b1, 8'd0, 8'h00, 8'h00, 1'b1, 1'b1, 8'd9},   // R9 Z set by load
        '{8'hFB, 8'h00, 1'b0, 8'd0, 8'h00, 8'h00, 1'b1, 1'b1, 8'd5},   // R5 MOV R3,A
        '{8'h74, 8'hAA, 1'b1, 8'd0, 8'h00, 8'hAA, 1'b1, 1'b0, 8'd5},   // R5
        '{8'hEB, 8'h00, 1'b0, 8'd0, 8'h00, 8'h00, 1'b1, 1'b1, 8'd9}    // R9 MOV A,R3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr;
    logic       mem_rd_n;
    logic [7:0] mem_data;
    logic [7:0] acc_out;
    logic       c_out;
    logic       z_out;
    logic [7:0] rom [256];
    int         start [NV+1];
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign mem_data = mem_rd_n ? 8'h5A : rom[mem_addr];

    acc8_core u_acc8_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .mem_rd_n (mem_rd_n),
        .mem_data (mem_data),
        .acc_out  (acc_out),
        .c_out    (c_out),
        .z_out    (z_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int a;
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        a = 0;
        for (int i = 0; i < NV; i++) begin
            start[i] = a;
            rom[a] = VEC[i].op;
            a++;
            if (VEC[i].two) begin rom[a] = VEC[i].arg; a++; end
            for (int p = 0; p < int'(VEC[i].pad_n); p++) begin rom[a] = VEC[i].pad_b; a++; end
        end
        start[NV] = a;

        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 addr", mem_addr, 0);
        check("R1 acc", acc_out, 0);
        check("R1 carry", c_out, 0);
        check("R1 zero", z_out, 0);
        check("R1 fetch enable", mem_rd_n, 0);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VEC[i].req, i);
            check({"R3 fetch addr ", t}, mem_addr, start[i]);
            check({"R2 fetch rd_n ", t}, mem_rd_n, 0);
            step();
            check({"R4 decode rd_n ", t}, mem_rd_n, !VEC[i].two);
            check({"R3 decode addr ", t}, mem_addr, start[i] + 1);
            step();
            check({"R2 exec rd_n ", t}, mem_rd_n, 1);
            step();
            check({t, " acc"}, acc_out, VEC[i].acc);
            check({t, " carry"}, c_out, VEC[i].c);
            check({t, " zero"}, z_out, VEC[i].z);
            check({t, " next addr"}, mem_addr, start[i+1]);
        end

        // Directed: backward jump onto itself (R10).
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        rom[0] = 8'h74; rom[1] = 8'h55; rom[2] = 8'hFD; rom[3] = 8'h80; rom[4] = 8'hFE;
        repeat (2) step();
        rst_n = 1'b1;
        check("R1 addr after reset", mem_addr, 0);
        repeat (9) step();
        check("R5 acc before loop", acc_out, 8'h55);
        check("R10 backward jump addr", mem_addr, 3);
        repeat (3) step();
        check("R10 loop repeats addr", mem_addr, 3);

        // Directed: reset mid-run clears the register file (R1).
        rst_n = 1'b0;
        rom[0] = 8'hED;
        step();
        rst_n = 1'b1;
        check("R1 acc cleared", acc_out, 0);
        check("R1 addr restart", mem_addr, 0);
        repeat (3) step();
        check("R1 R5 cleared by reset", acc_out, 0);
        check("R1 zero after read", z_out, 1);
        check("R12 pc after one-byte", mem_addr, 1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule